// File: doc/BRIEF.md
# Serial Configuration Register Interface

This block is a three-wire serial slave that holds sixteen 8-bit configuration registers. A host lowers the active-low enable `sen_n` and clocks a 13-bit frame in on `sdi` with rising `sclk` edges. The frame carries a direction flag, a register address and a data byte. When the enable returns high, the block decodes the most recent 13 bits. A write frame stores its byte into the addressed register. A read frame leaves every register unchanged and arms a read-back.

During the next enable window, the armed register is returned on `sdo`, one bit per falling `sclk` edge, most significant bit first. The host can shift a new frame in during that same window. This lets a run of reads be pipelined, with each window returning the data requested by the window before it.

Writes are committed in the `mclk` domain after a two-flop synchronizer sees the enable rise. The rest of the chip reads every register in parallel through `regs_flat`.

Top module: `serial_cfg_regs`

## Requirements
- R1: `sdi` is shifted in only on rising `sclk` edges while `sen_n` is low; `sclk` edges while `sen_n` is high leave the decoded frame unchanged.
- R2: A frame is sent MSB first. Its bit 12 is the direction flag, bits 11:8 are the address and bits 7:0 are the data byte.
- R3: When `sen_n` rises, only the last 13 bits shifted in are decoded, however many clocks the window contained.
- R4: A flag of 0 stores the data byte into the addressed register, visible on `regs_flat[8*addr+7 : 8*addr]` within three `mclk` cycles after `sen_n` rises. No other register changes.
- R5: A flag of 1 changes no register, and the data byte of that frame is discarded.
- R6: After a read frame, in the next enable window, falling `sclk` edges 1 through 8 present bits 7 down to 0 of the addressed register on `sdo`.
- R7: `sdo` is low while `sen_n` is high, during a window with no read armed, and after the eighth falling edge of a read-out window.
- R8: A read request is armed for exactly one following window. A window whose frame is a write leaves nothing armed for the window after it.
- R9: The asynchronous active-low reset `rst_n` clears all registers to 0x00 and cancels an armed read.
- R10: Registers change only on `mclk` edges following a rise of `sen_n`, never during an enable window.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| mclk | input | 1 | System clock for the register file and commit logic |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Serial shift clock |
| sen_n | input | 1 | Active-low frame enable |
| sdi | input | 1 | Serial data in, sampled on rising `sclk` |
| sdo | output | 1 | Serial data out, updated on falling `sclk` |
| regs_flat | output | 128 | All sixteen registers, register n at bits 8n+7:8n |

## Verification
A wrong internal state in the write path is visible on `regs_flat` within three `mclk` cycles of the enable rising. A wrongly decoded address corrupts a neighbour's byte, and a wrongly decoded flag either drops a write or stores a read's discarded byte. A fault in the read path appears only one window later on `sdo`: a stale or missing armed address returns the wrong byte or zeros. A bad bit counter shows as a shifted byte or stray ones after the eighth edge. Sweeping every address through both writes and pipelined reads makes any address-dependent fault show up within the window that follows it.

// File: rtl/serial_cfg_regs.sv
`timescale 1ns/1ps
module serial_cfg_regs #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8
) (
  input  logic                            mclk,
  input  logic                            rst_n,
  input  logic                            sclk,
  input  logic                            sen_n,
  input  logic                            sdi,
  output logic                            sdo,
  output logic [(DATA_W<<ADDR_W)-1:0]     regs_flat
);
  localparam int NREG  = 1 << ADDR_W;
  localparam int FRAME = 1 + ADDR_W + DATA_W;
  localparam int CW    = $clog2(DATA_W + 2);

  logic [FRAME-1:0]  shreg;
  logic [DATA_W-1:0] regs [NREG];
  logic [2:0]        sen_sync;
  logic              sen_rise;
  logic              rd_pend;
  logic [ADDR_W-1:0] rd_addr;
  logic [CW-1:0]     fall_cnt;
  logic [DATA_W-1:0] rd_shift;
  logic              out_en;

  wire                  f_read = shreg[FRAME-1];
  wire [ADDR_W-1:0]     f_addr = shreg[FRAME-2 -: ADDR_W];
  wire [DATA_W-1:0]     f_data = shreg[DATA_W-1:0];

  always_ff @(posedge sclk or negedge rst_n)
    if (!rst_n)      shreg <= '0;
    else if (!sen_n) shreg <= {shreg[FRAME-2:0], sdi};

  always_ff @(posedge mclk or negedge rst_n)
    if (!rst_n) sen_sync <= '1;
    else        sen_sync <= {sen_sync[1:0], sen_n};

  assign sen_rise = sen_sync[1] & ~sen_sync[2];

  always_ff @(posedge mclk or negedge rst_n)
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
      rd_pend <= 1'b0;
      rd_addr <= '0;
    end else if (sen_rise) begin
      rd_pend <= f_read;
      rd_addr <= f_addr;
      if (!f_read) regs[f_addr] <= f_data;
    end

  always_ff @(negedge sclk or posedge sen_n or negedge rst_n)
    if (!rst_n)                       fall_cnt <= '0;
    else if (sen_n)                   fall_cnt <= '0;
    else if (fall_cnt <= CW'(DATA_W)) fall_cnt <= fall_cnt + 1'b1;

  assign out_en   = rd_pend && (fall_cnt != '0) && (fall_cnt <= CW'(DATA_W));
  assign rd_shift = regs[rd_addr] << (fall_cnt - 1'b1);
  assign sdo      = out_en & rd_shift[DATA_W-1];

  for (genvar g = 0; g < NREG; g++) begin : g_flat
    assign regs_flat[g*DATA_W +: DATA_W] = regs[g];
  end
endmodule

// File: rtl/serial_cfg_regs_chk.sv
`timescale 1ns/1ps
module serial_cfg_regs_chk #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8
) (
  input logic                        mclk,
  input logic                        rst_n,
  input logic                        sen_n,
  input logic                        sdo,
  input logic [(DATA_W<<ADDR_W)-1:0] regs_flat
);
  localparam int NREG = 1 << ADDR_W;

  logic [(DATA_W<<ADDR_W)-1:0] prev;
  logic [NREG-1:0]             chg;

  always_ff @(posedge mclk or negedge rst_n)
    if (!rst_n) prev <= '0;
    else        prev <= regs_flat;

  always_comb
    for (int i = 0; i < NREG; i++)
      chg[i] = prev[i*DATA_W +: DATA_W] != regs_flat[i*DATA_W +: DATA_W];

  // R4: a commit touches at most one register
  a_r4_single_target: assert property (@(posedge mclk) disable iff (!rst_n)
    $countones(chg) <= 1);

  // R7: output idles low outside enable windows
  a_r7_sdo_idle_low: assert property (@(posedge mclk) disable iff (!rst_n)
    sen_n |-> !sdo);

  // R10: a change needs the enable to have been high
  a_r10_change_after_rise: assert property (@(posedge mclk) disable iff (!rst_n)
    !$stable(regs_flat) |-> $past(sen_n));

  // R10: a long enable window keeps registers frozen
  a_r10_quiet_in_window: assert property (@(posedge mclk) disable iff (!rst_n)
    (!sen_n && !$past(sen_n) && !$past(sen_n, 2) && !$past(sen_n, 3)) |-> $stable(regs_flat));
endmodule

bind serial_cfg_regs serial_cfg_regs_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_chk (
  .mclk(mclk), .rst_n(rst_n), .sen_n(sen_n), .sdo(sdo), .regs_flat(regs_flat)
);

// File: tb/test_serial_cfg_regs.sv
`timescale 1ns/1ps
module test_serial_cfg_regs;
  logic mclk = 1'b0, rst_n = 1'b0, sclk = 1'b0, sen_n = 1'b1, sdi = 1'b0;
  logic sdo;
  logic [127:0] regs_flat;
  logic [7:0] mdl [16];
  int vecs = 0, errs = 0;

  always #4 mclk = ~mclk;

  serial_cfg_regs i_serial_cfg_regs (
    .mclk(mclk), .rst_n(rst_n), .sclk(sclk), .sen_n(sen_n),
    .sdi(sdi), .sdo(sdo), .regs_flat(regs_flat)
  );

  function automatic logic [127:0] mdl_flat();
    logic [127:0] f;
    for (int i = 0; i < 16; i++) f[i*8 +: 8] = mdl[i];
    return f;
  endfunction

  task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
    vecs++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic xfer(input int n, input logic [31:0] bits,
                      output logic [7:0] got, output logic tail_bad);
    got = '0; tail_bad = 1'b0;
    sen_n = 1'b0; #6;
    for (int i = n - 1; i >= 0; i--) begin
      sdi = bits[i];
      #4 sclk = 1'b1;
      #8 sclk = 1'b0;
      #2;
      if (n - i <= 8) got = {got[6:0], sdo};
      else if (sdo !== 1'b0) tail_bad = 1'b1;
      #4;
    end
    #4 sen_n = 1'b1;
    #48;
  endtask

  function automatic logic [12:0] frm(input logic rd, input logic [3:0] a, input logic [7:0] d);
    return {rd, a, d};
  endfunction

  initial begin
    #1600000;
    errs++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  == %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    logic [7:0] got;
    logic tb;
    for (int i = 0; i < 16; i++) mdl[i] = 8'h00;
    #20;
    check("R9 reset regs", regs_flat, '0);
    check("R7 reset sdo", sdo, 0);
    rst_n = 1'b1;
    #20;

    // R2 R4: write sweep over every address
    for (int a = 0; a < 16; a++) begin
      logic [7:0] v;
      v = 8'((a * 37 + 5) & 255);
      xfer(13, 32'(frm(1'b0, 4'(a), v)), got, tb);
      mdl[a] = v;
      check("R4 write sweep", regs_flat, mdl_flat());
      check("R7 no read armed", got, 0);
    end

    // R6 R5 R7: pipelined read sweep
    for (int a = 0; a < 16; a++) begin
      xfer(13, 32'(frm(1'b1, 4'(a), 8'h5A)), got, tb);
      if (a > 0) check("R6 read back", got, mdl[a-1]);
      check("R7 tail low", tb, 0);
    end
    xfer(13, 32'(frm(1'b0, 4'd0, mdl[0])), got, tb);
    check("R6 last read", got, mdl[15]);
    check("R7 tail low", tb, 0);
    check("R5 reads keep regs", regs_flat, mdl_flat());

    // R8: one window only
    xfer(13, 32'(frm(1'b1, 4'd9, 8'hFF)), got, tb);
    xfer(13, 32'(frm(1'b0, 4'd2, mdl[2])), got, tb);
    check("R8 armed window", got, mdl[9]);
    xfer(13, 32'(frm(1'b0, 4'd2, mdl[2])), got, tb);
    check("R8 expired", got, 0);

    // R3: extra leading clocks
    xfer(20, {12'h0, 7'h7F, frm(1'b0, 4'd3, 8'hC3)}, got, tb);
    mdl[3] = 8'hC3;
    check("R3 long write", regs_flat, mdl_flat());
    xfer(17, {15'h0, 4'hF, frm(1'b1, 4'd3, 8'h00)}, got, tb);
    xfer(13, 32'(frm(1'b0, 4'd3, 8'hC3)), got, tb);
    check("R3 long read", got, 8'hC3);

    // R1: clocks while disabled are ignored
    xfer(13, 32'(frm(1'b0, 4'd5, 8'h11)), got, tb);
    mdl[5] = 8'h11;
    sdi = 1'b1;
    for (int k = 0; k < 6; k++) begin
      #4 sclk = 1'b1; #8 sclk = 1'b0; #2;
      check("R7 sdo idle", sdo, 0);
      #2;
    end
    sen_n = 1'b0; #20; sen_n = 1'b1; #48;
    check("R1 ignored clocks", regs_flat, mdl_flat());

    // R9: reset cancels armed read
    xfer(13, 32'(frm(1'b1, 4'd7, 8'h00)), got, tb);
    rst_n = 1'b0; #10;
    for (int i = 0; i < 16; i++) mdl[i] = 8'h00;
    check("R9 reset regs", regs_flat, '0);
    rst_n = 1'b1; #20;
    xfer(13, 32'(frm(1'b0, 4'd1, 8'h00)), got, tb);
    check("R9 read cancelled", got, 0);
    xfer(13, 32'(frm(1'b0, 4'd15, 8'hA5)), got, tb);
    mdl[15] = 8'hA5;
    check("R4 top address", regs_flat, mdl_flat());

    $display("  == %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule